// File: doc/BRIEF.md
# Luma threshold and output word formatter

This block sits between a pixel assembler and a memory write engine in an image capture path. Each cycle it may accept one assembled pixel. A pixel carries a luma byte, a chroma byte and an RGB565 value. The chroma byte is the blue-difference sample on even pixels of a line and the red-difference sample on odd pixels. The block turns each pixel into a unit of 16, 8 or 1 bits, depending on the selected memory layout. It then packs the units, lowest bits first, into 32-bit words for the downstream writer.

A 2-bit format code selects among four layouts: interleaved luma/chroma, luma only, RGB555 and RGB565. Two mode inputs override the code. Monochrome mode forces the luma-only layout. Binary-luma mode compares each luma byte against a programmable 8-bit threshold and packs one bit per pixel. In both override modes the chroma and RGB inputs play no part. A pixel flagged as the last of its line closes the current word. If that word is partly filled, the empty upper bits are zero, so every line starts on a word boundary. Configuration is expected to stay constant within a line.

Top module: `luma_fmt_packer`

## Requirements
- R1: While reset is asserted, and after its release until a pixel is accepted, out_valid and out_eol are low. The first word after reset starts at bit 0.
- R2: Format code 2'b00, with both override modes off: each pixel contributes {chroma, luma} as 16 bits. Two pixels fill a word as luma0 in [7:0], chroma0 in [15:8], luma1 in [23:16] and chroma1 in [31:24].
- R3: Format code 2'b01: each pixel contributes its luma byte. Four pixels fill a word, and the first pixel goes in [7:0].
- R4: Format code 2'b10: each pixel contributes {1'b0, rgb[15:11], rgb[10:6], rgb[4:0]}. The green LSB is dropped, and the first pixel goes in [15:0].
- R5: Format code 2'b11: each pixel contributes rgb[15:0] unchanged, and the first pixel goes in [15:0].
- R6: Binary-luma mode high: each pixel contributes one bit. Thirty-two pixels fill a word, and the first pixel goes in bit 0. The format code, chroma and RGB inputs have no effect on the output.
- R7: Monochrome mode high with binary-luma mode low: the luma-only layout of R3 is used whatever the format code. Chroma and RGB have no effect.
- R8: A word that fills completely is presented with out_valid high in the cycle after the pixel that fills it. out_eol is high only if that pixel was the last of its line.
- R9: A pixel flagged with in_eol causes a word with out_valid and out_eol high in the next cycle. Any unfilled upper bits of that word are zero, and the next pixel starts a new word at bit 0.
- R10: out_valid is high only in the cycle after an accepted pixel. Cycles with in_valid low leave the partly filled word unchanged.
- R11: In binary-luma mode a luma value equal to the threshold gives 1, and a value one below the threshold gives 0. A threshold of 0 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Output layout code: 00 luma/chroma, 01 luma only, 10 RGB555, 11 RGB565 |
| cfg_bin_luma | input | 1 | Binary-luma mode, one bit per pixel |
| cfg_mono | input | 1 | Monochrome mode, forces luma-only |
| cfg_thresh | input | 8 | Binary-luma threshold |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_eol | input | 1 | Pixel is the last of its line |
| in_luma | input | 8 | Luma byte |
| in_chroma | input | 8 | Chroma byte (blue-difference on even pixels, red-difference on odd) |
| in_rgb | input | 16 | RGB565 pixel {R[4:0], G[5:0], B[4:0]} |
| out_valid | output | 1 | Packed word valid |
| out_word | output | 32 | Packed word, first pixel in the lowest bits |
| out_eol | output | 1 | Word is the last of its line |

## Verification
The assertions check on every cycle that output words appear only after accepted pixels, and that a line end always yields a flagged word in the next cycle. They also check that every unflagged word carries exactly the pixel count its layout implies (2, 4 or 32), and that a flagged word carries between one and that many. The bench's scenarios alone show bit placement and field contents: the byte order of the interleaved layout, the green-LSB drop of RGB555, and zero padding of partial words. The same holds for the threshold boundary and for the format code, chroma and RGB inputs being ignored in the override modes.

// File: rtl/luma_fmt_pkg.sv
package luma_fmt_pkg;

  localparam int LUMA_W = 8;
  localparam int UNIT_W = 16;

  typedef enum logic [1:0] {
    FMT_YC     = 2'b00,
    FMT_Y8     = 2'b01,
    FMT_RGB555 = 2'b10,
    FMT_RGB565 = 2'b11
  } out_fmt_e;

  typedef enum logic [1:0] {
    UW_1  = 2'd0,
    UW_8  = 2'd1,
    UW_16 = 2'd2
  } unit_w_e;

  function automatic int unsigned unit_bits(unit_w_e w);
    case (w)
      UW_1:    return 1;
      UW_8:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/luma_fmt_unit.sv
module luma_fmt_unit
  import luma_fmt_pkg::*;
(
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_bin_luma,
  input  logic              cfg_mono,
  input  logic [LUMA_W-1:0] cfg_thresh,
  input  logic [LUMA_W-1:0] luma,
  input  logic [LUMA_W-1:0] chroma,
  input  logic [15:0]       rgb,
  output logic [UNIT_W-1:0] unit,
  output unit_w_e           unit_w
);

  out_fmt_e fmt;
  logic     luma_bit;

  assign fmt      = out_fmt_e'(cfg_fmt);
  assign luma_bit = (luma >= cfg_thresh);

  always_comb begin
    unit   = '0;
    unit_w = UW_16;
    if (cfg_bin_luma) begin
      unit   = {{(UNIT_W-1){1'b0}}, luma_bit};
      unit_w = UW_1;
    end else if (cfg_mono) begin
      unit   = {{(UNIT_W-LUMA_W){1'b0}}, luma};
      unit_w = UW_8;
    end else begin
      case (fmt)
        FMT_YC: begin
          unit   = {chroma, luma};
          unit_w = UW_16;
        end
        FMT_Y8: begin
          unit   = {{(UNIT_W-LUMA_W){1'b0}}, luma};
          unit_w = UW_8;
        end
        FMT_RGB555: begin
          unit   = {1'b0, rgb[15:11], rgb[10:6], rgb[4:0]};
          unit_w = UW_16;
        end
        default: begin
          unit   = rgb;
          unit_w = UW_16;
        end
      endcase
    end
  end

endmodule

// File: rtl/luma_word_packer.sv
module luma_word_packer
  import luma_fmt_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_eol,
  input  logic [UNIT_W-1:0] unit,
  input  unit_w_e           unit_w,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_eol
);

  localparam int POS_W  = $clog2(WORD_W);
  localparam int FILL_W = POS_W + 1;

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              vld_q, vld_d;
  logic              eol_q, eol_d;
  logic [WORD_W-1:0] word_q, word_d;

  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] merged;
  logic [FILL_W-1:0] fill;
  logic              full;
  logic              emit;

  assign placed = {{(WORD_W-UNIT_W){1'b0}}, unit} << pos_q;
  assign merged = acc_q | placed;
  assign fill   = {1'b0, pos_q} + FILL_W'(unit_bits(unit_w));
  assign full   = (fill == FILL_W'(WORD_W));
  assign emit   = in_valid && (full || in_eol);

  always_comb begin
    acc_d  = acc_q;
    pos_d  = pos_q;
    word_d = word_q;
    vld_d  = emit;
    eol_d  = emit && in_eol;
    if (in_valid) begin
      if (emit) begin
        acc_d  = '0;
        pos_d  = '0;
        word_d = merged;
      end else begin
        acc_d = merged;
        pos_d = fill[POS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pos_q  <= '0;
      vld_q  <= 1'b0;
      eol_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= vld_d;
      eol_q <= eol_d;
      if (in_valid) begin
        acc_q <= acc_d;
        pos_q <= pos_d;
      end
      if (emit) begin
        word_q <= word_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
  assign out_eol   = eol_q;

endmodule

// File: rtl/luma_fmt_packer.sv
module luma_fmt_packer
  import luma_fmt_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_bin_luma,
  input  logic              cfg_mono,
  input  logic [7:0]        cfg_thresh,
  input  logic              in_valid,
  input  logic              in_eol,
  input  logic [7:0]        in_luma,
  input  logic [7:0]        in_chroma,
  input  logic [15:0]       in_rgb,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_eol
);

  logic [UNIT_W-1:0] unit;
  unit_w_e           unit_w;

  luma_fmt_unit u_fmt (
    .cfg_fmt      (cfg_fmt),
    .cfg_bin_luma (cfg_bin_luma),
    .cfg_mono     (cfg_mono),
    .cfg_thresh   (cfg_thresh),
    .luma         (in_luma),
    .chroma       (in_chroma),
    .rgb          (in_rgb),
    .unit         (unit),
    .unit_w       (unit_w)
  );

  luma_word_packer #(.WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eol    (in_eol),
    .unit      (unit),
    .unit_w    (unit_w),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_eol   (out_eol)
  );

endmodule

// File: rtl/luma_fmt_packer_chk.sv
module luma_fmt_packer_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_fmt,
  input logic              cfg_bin_luma,
  input logic              cfg_mono,
  input logic              in_valid,
  input logic              in_eol,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              out_eol
);

  localparam int CNT_W = $clog2(WORD_W) + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_word;

  // pixels a full word must hold for the current configuration
  always_comb begin
    if (cfg_bin_luma)                    per_word = CNT_W'(WORD_W);
    else if (cfg_mono || cfg_fmt == 2'b01) per_word = CNT_W'(WORD_W / 8);
    else                                 per_word = CNT_W'(WORD_W / 16);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= (out_valid ? '0 : cnt_q) + CNT_W'(in_valid);
  end

  assert_valid_after_pixel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_eol_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  assert_line_end_flushes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eol) |-> (out_valid && out_eol));

  assert_full_word_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eol) |-> (cnt_q == $past(per_word)));

  assert_partial_word_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eol) |-> (cnt_q != '0 && cnt_q <= $past(per_word)));

endmodule

bind luma_fmt_packer luma_fmt_packer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_fmt      (cfg_fmt),
  .cfg_bin_luma (cfg_bin_luma),
  .cfg_mono     (cfg_mono),
  .in_valid     (in_valid),
  .in_eol       (in_eol),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .out_eol      (out_eol)
);

// File: tb/luma_fmt_packer_tb.sv
`timescale 1ns/1ps
module luma_fmt_packer_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_fmt;
  logic        cfg_bin_luma;
  logic        cfg_mono;
  logic [7:0]  cfg_thresh;
  logic        in_valid;
  logic        in_eol;
  logic [7:0]  in_luma;
  logic [7:0]  in_chroma;
  logic [15:0] in_rgb;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_eol;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bit          mq[$];
  logic        exp_valid;
  logic [31:0] exp_word;
  logic        exp_eol;

  luma_fmt_packer #(.WORD_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_bin_luma(cfg_bin_luma),
    .cfg_mono(cfg_mono), .cfg_thresh(cfg_thresh), .in_valid(in_valid),
    .in_eol(in_eol), .in_luma(in_luma), .in_chroma(in_chroma), .in_rgb(in_rgb),
    .out_valid(out_valid), .out_word(out_word), .out_eol(out_eol)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=completion");
    summary();
    $finish;
  end

  task automatic check_outputs();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s out_valid: actual=%b expected=%b", cur_req, out_valid, exp_valid);
    end else if (exp_valid) begin
      checks++;
      if (out_word !== exp_word || out_eol !== exp_eol) begin
        errors++;
        $display("FAIL %s word/eol: actual=%h/%b expected=%h/%b",
                 cur_req, out_word, out_eol, exp_word, exp_eol);
      end
    end
  endtask

  task automatic push_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) mq.push_back(v[i]);
  endtask

  // behavioural model: bits queued LSB first, a word leaves when 32 bits or line end
  task automatic model_pixel(input logic [7:0] y, input logic [7:0] c,
                             input logic [15:0] rgb, input logic eol);
    if (cfg_bin_luma) push_bits({15'd0, (y >= cfg_thresh)}, 1);
    else if (cfg_mono || cfg_fmt == 2'b01) push_bits({8'd0, y}, 8);
    else if (cfg_fmt == 2'b00) push_bits({c, y}, 16);
    else if (cfg_fmt == 2'b10) push_bits({1'b0, rgb[15:11], rgb[10:6], rgb[4:0]}, 16);
    else push_bits(rgb, 16);
    exp_valid = 1'b0;
    if (mq.size() >= 32 || eol) begin
      exp_word = '0;
      for (int i = 0; i < 32; i++) if (mq.size() > 0) exp_word[i] = mq.pop_front();
      exp_valid = 1'b1;
      exp_eol   = eol;
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] y, input logic [7:0] c,
                       input logic [15:0] rgb, input logic eol);
    @(negedge clk);
    check_outputs();
    in_valid  = v;
    in_luma   = y;
    in_chroma = c;
    in_rgb    = rgb;
    in_eol    = v && eol;
    if (v) model_pixel(y, c, rgb, eol);
    else   exp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 8'h00, 16'h0000, 1'b0);
  endtask

  task automatic cfg(input logic [1:0] f, input logic b, input logic m, input logic [7:0] t);
    idle(2);
    cfg_fmt = f; cfg_bin_luma = b; cfg_mono = m; cfg_thresh = t;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 0; in_eol = 0; in_luma = 0; in_chroma = 0; in_rgb = 0;
    cfg_fmt = 2'b00; cfg_bin_luma = 0; cfg_mono = 0; cfg_thresh = 8'h80;
    exp_valid = 0; exp_word = 0; exp_eol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    checks++;
    if (out_valid !== 1'b0 || out_eol !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%b%b expected=00", out_valid, out_eol);
    end
    rst_n = 1'b1;
    idle(3);

    // R2 interleaved luma/chroma, 5 pixels: two full words then a padded one (R9)
    cur_req = "R2";
    for (int i = 0; i < 5; i++)
      drive(1'b1, 8'h10 + 8'(i), (i % 2 == 0) ? 8'hB0 : 8'hC0, 16'hFFFF, i == 4);

    // R3 luma only with idle gaps (R10), 10 pixels
    cfg(2'b01, 0, 0, 8'h80);
    cur_req = "R3 R10";
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 8'hA0 + 8'(i), 8'h55, 16'h1234, i == 9);
      if (i % 3 == 1) idle(2);
    end

    // R4 RGB555 green LSB dropped
    cfg(2'b10, 0, 0, 8'h80);
    cur_req = "R4";
    drive(1'b1, 8'h00, 8'h00, 16'hF81F, 1'b0);
    drive(1'b1, 8'h00, 8'h00, 16'h07E0, 1'b0);
    drive(1'b1, 8'h00, 8'h00, 16'h0021, 1'b1);

    // R5 RGB565 unchanged
    cfg(2'b11, 0, 0, 8'h80);
    cur_req = "R5";
    for (int i = 0; i < 4; i++) drive(1'b1, 8'h00, 8'h00, 16'h1357 + 16'(i * 16'h1111), i == 3);

    // R6/R11 binary luma, format code 11 and chroma/rgb varied yet ignored, 70 pixels
    cfg(2'b11, 1, 0, 8'h80);
    cur_req = "R6 R11";
    for (int i = 0; i < 70; i++) begin
      logic [7:0] y;
      y = (i % 4 == 0) ? 8'h80 : (i % 4 == 1) ? 8'h7F : 8'(i * 37);
      drive(1'b1, y, 8'(i * 5), 16'(i * 977), i == 69);
    end

    // R11 threshold 0 gives all ones; threshold FF only at FF
    cfg(2'b00, 1, 0, 8'h00);
    cur_req = "R11";
    for (int i = 0; i < 32; i++) drive(1'b1, 8'(i * 8), 8'h00, 16'h0000, i == 31);
    cfg(2'b10, 1, 0, 8'hFF);
    for (int i = 0; i < 9; i++) drive(1'b1, (i % 2 == 0) ? 8'hFF : 8'hFE, 8'h00, 16'h0, i == 8);

    // R7 monochrome forces luma-only despite format code 00
    cfg(2'b00, 0, 1, 8'h80);
    cur_req = "R7";
    for (int i = 0; i < 7; i++) drive(1'b1, 8'h60 + 8'(i), 8'hEE, 16'hABCD, i == 6);

    // R8 full word ending exactly on a line end, then back-to-back lines (R9)
    cfg(2'b01, 0, 0, 8'h80);
    cur_req = "R8 R9";
    for (int i = 0; i < 4; i++) drive(1'b1, 8'h20 + 8'(i), 8'h00, 16'h0, i == 3);
    for (int i = 0; i < 6; i++) drive(1'b1, 8'h30 + 8'(i), 8'h00, 16'h0, i == 1 || i == 5);

    idle(4);
    summary();
    $finish;
  end

endmodule